// File: doc/BRIEF.md
# Parameter-Queued Copy/Fill Engine

This block is the command engine of a cartridge coprocessor. It moves bytes out of the ROM image into a 4 KB display-data RAM, or sets a run of that RAM to one value. The host CPU does not hand it a whole descriptor at once. It stores arguments one byte at a time into a single parameter register, and an internal slot index advances after each store. A write to the function register then decodes a command code. Code 1 copies, code 2 fills and code 0 rewinds the slot index.

The destination of a transfer is the current pointer of one of several data fetchers. The engine walks the RAM with its own counter, so the fetcher pointer still holds its starting value when the transfer ends. The engine moves one byte per clock. It reads a synchronous ROM that returns data one cycle after the address and writes the RAM through a registered write port. A busy output covers the whole transfer, and host writes made while busy is high are dropped.

Top module: `copy_fill_engine`

## Requirements
- R1: After a synchronous reset, `busy` and `ram_we` are 0, every fetcher pointer reads back 0 and the parameter slot index is 0.
- R2: A host write with `reg_fn`=0 stores `reg_wdata` in slot[index]. The index then advances 0→1→2→3 and wraps from 3 back to 0, so a fifth write overwrites slot 0.
- R3: Function code 1 (host write with `reg_fn`=1, data 8'h01) copies. Slot 0 is the source low byte, slot 1 the source high byte, slot 2 the fetcher number and slot 3 the byte count. Byte k is read from ROM offset ({slot1,slot0}+k) mod 2^ROM_AW and written to RAM address (pointer+k) mod 4096. The ROM returns data one cycle after `rom_addr`.
- R4: Function code 2 (data 8'h02) fills. Slot 0 holds the fill value, slot 1 repeats it, and slots 2 and 3 are the fetcher number and byte count. Each of the count bytes starting at the fetcher pointer receives the slot 0 value.
- R5: Function code 0 sets the slot index to 0. Codes 1 and 2 also set it to 0 when they start. Any other code changes nothing.
- R6: The low log2(NUM_FETCH) bits of slot 2 select the fetcher. Its pointer gives the first destination address and keeps its value after the transfer.
- R7: A byte count of 0 performs no RAM write and leaves `busy` low. A count N of 1..255 performs exactly N RAM writes to consecutive addresses.
- R8: `busy` rises on the clock edge that samples the function write and stays high for exactly N+2 cycles, covering the last RAM write.
- R9: Host writes to either register while `busy` is high are ignored. They start nothing and do not move the slot index.
- R10: Destination addresses wrap from 4095 to 0, and source offsets wrap at 2^ROM_AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_fn | input | 1 | 0 selects the parameter register, 1 the function register |
| reg_wdata | input | 8 | Host write data |
| ptr_we | input | 1 | Fetcher pointer write strobe |
| ptr_sel | input | log2(NUM_FETCH) | Fetcher to load |
| ptr_wdata | input | RAM_AW | New pointer value |
| ptr_rd_sel | input | log2(NUM_FETCH) | Fetcher to read back |
| ptr_rd_data | output | RAM_AW | Pointer of the selected fetcher |
| rom_addr | output | ROM_AW | ROM image byte offset |
| rom_rdata | input | 8 | ROM data, one cycle after the address |
| ram_we | output | 1 | Display RAM write enable |
| ram_waddr | output | RAM_AW | Display RAM write address |
| ram_wdata | output | 8 | Display RAM write data |
| busy | output | 1 | Transfer in progress |

## Verification
The bench uses the default build: ROM_AW=15 for a 32 KB image, RAM_AW=12 for the 4 KB display RAM, and eight fetchers. With these values a copy from the display-bank image at $6000 is in reach. So are a source run that crosses $7FFF back to 0, a destination run that crosses $FFF back to 0, and a selection among all eight fetcher pointers. Because the count is eight bits, the largest transfer of 255 bytes and the empty transfer both fit in a short run. The bench observes the busy window and the number of RAM writes for each of them.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_SLOTS = 4;
  localparam logic [BYTE_W-1:0] FN_REWIND = 8'h00;
  localparam logic [BYTE_W-1:0] FN_COPY   = 8'h01;
  localparam logic [BYTE_W-1:0] FN_FILL   = 8'h02;
  localparam int SLOT_A0  = 0;
  localparam int SLOT_A1  = 1;
  localparam int SLOT_SEL = 2;
  localparam int SLOT_CNT = 3;
endpackage

// File: rtl/cfe_param_slots.sv
module cfe_param_slots #(
  parameter int NSLOT = 4,
  parameter int DW    = 8,
  localparam int IW   = $clog2(NSLOT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [DW-1:0]       wdata,
  input  logic                rewind,
  output logic [NSLOT*DW-1:0] slots_flat,
  output logic [IW-1:0]       idx
);
  logic [DW-1:0] slot_q [NSLOT];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
    end else if (rewind) begin
      idx <= '0;
    end else if (wr_en) begin
      slot_q[idx] <= wdata;
      idx <= (idx == IW'(NSLOT-1)) ? '0 : idx + 1'b1;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_flat
    assign slots_flat[g*DW +: DW] = slot_q[g];
  end

  // R2
  slot_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rewind) |=> (slot_q[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/cfe_fetch_bank.sv
module cfe_fetch_bank #(
  parameter int NF  = 8,
  parameter int AW  = 12,
  localparam int SW = $clog2(NF)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [AW-1:0] wdata,
  input  logic [SW-1:0] rsel_a,
  output logic [AW-1:0] rdata_a,
  input  logic [SW-1:0] rsel_b,
  output logic [AW-1:0] rdata_b
);
  logic [AW-1:0]    ptr_q [NF];
  logic [NF*AW-1:0] ptr_flat;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NF; i++) ptr_q[i] <= '0;
    end else if (we) begin
      ptr_q[wsel] <= wdata;
    end
  end

  assign rdata_a = ptr_q[rsel_a];
  assign rdata_b = ptr_q[rsel_b];

  for (genvar g = 0; g < NF; g++) begin : g_flat
    assign ptr_flat[g*AW +: AW] = ptr_q[g];
  end

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(ptr_flat));
endmodule

// File: rtl/cfe_xfer.sv
module cfe_xfer #(
  parameter int ROM_AW = 15,
  parameter int RAM_AW = 12,
  parameter int CNT_W  = 8,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_fill,
  input  logic [ROM_AW-1:0] src,
  input  logic [RAM_AW-1:0] dst,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DW-1:0]     fill_val,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [DW-1:0]     rom_rdata,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_waddr,
  output logic [DW-1:0]     ram_wdata,
  output logic              busy
);
  logic              issuing, rd_vld, fill_q;
  logic [CNT_W-1:0]  left;
  logic [ROM_AW-1:0] rd_ptr;
  logic [RAM_AW-1:0] wr_ptr;
  logic [DW-1:0]     val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      issuing   <= 1'b0;
      rd_vld    <= 1'b0;
      fill_q    <= 1'b0;
      left      <= '0;
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      val_q     <= '0;
      ram_we    <= 1'b0;
      ram_waddr <= '0;
      ram_wdata <= '0;
    end else begin
      if (start && !busy && cnt != '0) begin
        issuing <= 1'b1;
        left    <= cnt;
        rd_ptr  <= src;
        wr_ptr  <= dst;
        fill_q  <= is_fill;
        val_q   <= fill_val;
      end else if (issuing) begin
        rd_ptr <= rd_ptr + 1'b1;
        left   <= left - 1'b1;
        if (left == CNT_W'(1)) issuing <= 1'b0;
      end
      rd_vld <= issuing;
      ram_we <= rd_vld;
      if (rd_vld) begin
        ram_waddr <= wr_ptr;
        ram_wdata <= fill_q ? val_q : rom_rdata;
        wr_ptr    <= wr_ptr + 1'b1;
      end
    end
  end

  assign rom_addr = rd_ptr;
  assign busy     = issuing | rd_vld | ram_we;

  // R7
  consec_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_we && $past(ram_we)) |-> (ram_waddr == $past(ram_waddr) + 1'b1));
  // R10
  consec_read_chk: assert property (@(posedge clk) disable iff (rst)
    (issuing && $past(issuing)) |-> (rom_addr == $past(rom_addr) + 1'b1));
  // R8
  busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R7
  no_idle_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy) |=> !ram_we);
endmodule

// File: rtl/copy_fill_engine.sv
module copy_fill_engine
  import cfe_pkg::*;
#(
  parameter int ROM_AW    = 15,
  parameter int RAM_AW    = 12,
  parameter int NUM_FETCH = 8,
  localparam int FSEL_W   = $clog2(NUM_FETCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_fn,
  input  logic [7:0]        reg_wdata,
  input  logic              ptr_we,
  input  logic [FSEL_W-1:0] ptr_sel,
  input  logic [RAM_AW-1:0] ptr_wdata,
  input  logic [FSEL_W-1:0] ptr_rd_sel,
  output logic [RAM_AW-1:0] ptr_rd_data,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_rdata,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_waddr,
  output logic [7:0]        ram_wdata,
  output logic              busy
);
  localparam int IW = $clog2(N_SLOTS);

  logic                      host_param, host_fn, do_copy, do_fill, rewind;
  logic [N_SLOTS*BYTE_W-1:0] slots_flat;
  logic [IW-1:0]             slot_idx;
  logic [BYTE_W-1:0]         a0, a1, sel_b, cnt_b;
  logic [15:0]               src16;
  logic [RAM_AW-1:0]         eng_ptr;
  logic                      unused_bits;

  assign host_param = reg_wr && !reg_fn && !busy;
  assign host_fn    = reg_wr &&  reg_fn && !busy;
  assign do_copy    = host_fn && (reg_wdata == FN_COPY);
  assign do_fill    = host_fn && (reg_wdata == FN_FILL);
  assign rewind     = do_copy || do_fill || (host_fn && reg_wdata == FN_REWIND);

  cfe_param_slots #(.NSLOT(N_SLOTS), .DW(BYTE_W)) u_slots (
    .clk(clk), .rst(rst), .wr_en(host_param), .wdata(reg_wdata),
    .rewind(rewind), .slots_flat(slots_flat), .idx(slot_idx)
  );

  assign a0    = slots_flat[SLOT_A0*BYTE_W  +: BYTE_W];
  assign a1    = slots_flat[SLOT_A1*BYTE_W  +: BYTE_W];
  assign sel_b = slots_flat[SLOT_SEL*BYTE_W +: BYTE_W];
  assign cnt_b = slots_flat[SLOT_CNT*BYTE_W +: BYTE_W];
  assign src16 = {a1, a0};
  assign unused_bits = ^{src16, sel_b, slot_idx};

  cfe_fetch_bank #(.NF(NUM_FETCH), .AW(RAM_AW)) u_fetch (
    .clk(clk), .rst(rst), .we(ptr_we), .wsel(ptr_sel), .wdata(ptr_wdata),
    .rsel_a(ptr_rd_sel), .rdata_a(ptr_rd_data),
    .rsel_b(sel_b[FSEL_W-1:0]), .rdata_b(eng_ptr)
  );

  cfe_xfer #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW), .CNT_W(BYTE_W), .DW(BYTE_W)) u_xfer (
    .clk(clk), .rst(rst), .start(do_copy || do_fill), .is_fill(do_fill),
    .src(src16[ROM_AW-1:0]), .dst(eng_ptr), .cnt(cnt_b), .fill_val(a0),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .busy(busy)
  );

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr) |=> $stable(slot_idx));
  // R5
  rewind_chk: assert property (@(posedge clk) disable iff (rst)
    (host_fn && reg_wdata == FN_REWIND) |=> (slot_idx == '0));
endmodule

// File: tb/tb_copy_fill_engine.sv
module tb_copy_fill_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_fn = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic        ptr_we = 1'b0;
  logic [2:0]  ptr_sel = '0, ptr_rd_sel = '0;
  logic [11:0] ptr_wdata = '0;
  logic [11:0] ptr_rd_data;
  logic [14:0] rom_addr;
  logic [7:0]  rom_rdata = '0;
  logic        ram_we;
  logic [11:0] ram_waddr;
  logic [7:0]  ram_wdata;
  logic        busy;

  int checks = 0, fails = 0, wr_cnt = 0;
  logic [7:0] mem [4096];
  logic [7:0] expm [4096];

  always #2.5 clk = ~clk;

  copy_fill_engine dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_fn(reg_fn), .reg_wdata(reg_wdata),
    .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
    .ptr_rd_sel(ptr_rd_sel), .ptr_rd_data(ptr_rd_data),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .busy(busy)
  );

  function automatic logic [7:0] rom_f(input int a);
    logic [14:0] x;
    x = 15'(a);
    return x[7:0] ^ {x[14:8], 1'b1};
  endfunction

  always @(posedge clk) rom_rdata <= rom_f(int'(rom_addr));
  always @(posedge clk) if (ram_we) begin
    mem[ram_waddr] <= ram_wdata;
    wr_cnt = wr_cnt + 1;
  end

  typedef struct packed {
    logic [2:0]  f;
    logic [11:0] p;
    logic [7:0]  code;
    logic [15:0] src;
    logic [7:0]  val;
    logic [7:0]  n;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{3'd0, 12'h100, 8'h01, 16'h6000, 8'h00, 8'd16},
    '{3'd3, 12'h200, 8'h02, 16'h0000, 8'hA5, 8'd40},
    '{3'd7, 12'hFF8, 8'h01, 16'h1234, 8'h00, 8'd20},
    '{3'd5, 12'h000, 8'h01, 16'h7FF0, 8'h00, 8'd32},
    '{3'd2, 12'h800, 8'h02, 16'h0000, 8'h3C, 8'd255},
    '{3'd1, 12'h300, 8'h01, 16'h4000, 8'h00, 8'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_write(input logic fn, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_fn = fn; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_ptr(input int f, input int p);
    @(negedge clk);
    ptr_we = 1'b1; ptr_sel = 3'(f); ptr_wdata = 12'(p);
    @(negedge clk);
    ptr_we = 1'b0;
  endtask

  task automatic model_op(input bit fill, input int src, input int val, input int p, input int n);
    for (int k = 0; k < n; k++)
      expm[(p + k) & 12'hFFF] = fill ? 8'(val) : rom_f((src + k) & 15'h7FFF);
  endtask

  task automatic load_args(input logic [7:0] code, input vec_t v);
    if (code == 8'h02) begin
      host_write(1'b0, v.val); host_write(1'b0, v.val);
    end else begin
      host_write(1'b0, v.src[7:0]); host_write(1'b0, v.src[15:8]);
    end
    host_write(1'b0, {5'd0, v.f});
    host_write(1'b0, v.n);
  endtask

  task automatic wait_busy(output int cyc);
    cyc = 0;
    while (busy && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic mem_cmp(input string req);
    int bad = 0;
    for (int a = 0; a < 4096; a++) if (mem[a] !== expm[a]) bad++;
    check(req, bad, 0);
  endtask

  initial begin
    int cyc, w0;
    vec_t v;
    for (int a = 0; a < 4096; a++) begin mem[a] = 8'h00; expm[a] = 8'h00; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 ram_we", int'(ram_we), 0);
    for (int f = 0; f < 8; f++) begin
      ptr_rd_sel = 3'(f); #0.1;
      check("R1 ptr", int'(ptr_rd_data), 0);
    end
    for (int f = 0; f < 8; f++) set_ptr(f, f * 'h1F0 + 5);

    // table of vectors: R3 R4 R6 R7 R8 R10
    for (int i = 0; i < 6; i++) begin
      v = VECS[i];
      set_ptr(int'(v.f), int'(v.p));
      load_args(v.code, v);
      w0 = wr_cnt;
      host_write(1'b1, v.code);
      wait_busy(cyc);
      check("R8 busy cycles", cyc, (v.n == 0) ? 0 : int'(v.n) + 2);
      check("R7 write count", wr_cnt - w0, int'(v.n));
      model_op(v.code == 8'h02, int'(v.src), int'(v.val), int'(v.p), int'(v.n));
      mem_cmp((v.code == 8'h02) ? "R4 fill image" : "R3 R10 copy image");
      ptr_rd_sel = v.f; #0.1;
      check("R6 pointer kept", int'(ptr_rd_data), int'(v.p));
    end

    // R5: code 0 rewinds the slot index
    v = '{3'd4, 12'h500, 8'h01, 16'h2345, 8'h00, 8'd12};
    set_ptr(4, 'h500);
    host_write(1'b0, 8'hEE); host_write(1'b0, 8'hDD);
    host_write(1'b1, 8'h00);
    load_args(8'h01, v);
    host_write(1'b1, 8'h01);
    wait_busy(cyc);
    model_op(1'b0, 'h2345, 0, 'h500, 12);
    mem_cmp("R5 rewind then copy");

    // R5: unknown code leaves slots and index alone
    set_ptr(6, 'h600);
    host_write(1'b0, 8'h11); host_write(1'b0, 8'h52);
    host_write(1'b1, 8'h07);
    host_write(1'b0, 8'h06); host_write(1'b0, 8'd9);
    host_write(1'b1, 8'h01);
    wait_busy(cyc);
    model_op(1'b0, 'h5211, 0, 'h600, 9);
    mem_cmp("R5 unknown code ignored");

    // R2: fifth write wraps into slot 0
    set_ptr(1, 'h700);
    host_write(1'b0, 8'h99); host_write(1'b0, 8'h31);
    host_write(1'b0, 8'h01); host_write(1'b0, 8'd7);
    host_write(1'b0, 8'h44);
    host_write(1'b1, 8'h01);
    wait_busy(cyc);
    model_op(1'b0, 'h3144, 0, 'h700, 7);
    mem_cmp("R2 slot wrap");

    // R9: writes while busy are dropped
    set_ptr(0, 'hA00);
    host_write(1'b0, 8'h5A); host_write(1'b0, 8'h5A);
    host_write(1'b0, 8'h00); host_write(1'b0, 8'd50);
    w0 = wr_cnt;
    host_write(1'b1, 8'h02);
    host_write(1'b0, 8'h77); host_write(1'b0, 8'h66);
    host_write(1'b1, 8'h01);
    wait_busy(cyc);
    check("R9 no restart", wr_cnt - w0, 50);
    model_op(1'b1, 0, 'h5A, 'hA00, 50);
    set_ptr(0, 'hB00);
    v = '{3'd0, 12'hB00, 8'h01, 16'h0ABC, 8'h00, 8'd10};
    load_args(8'h01, v);
    host_write(1'b1, 8'h01);
    wait_busy(cyc);
    model_op(1'b0, 'h0ABC, 0, 'hB00, 10);
    mem_cmp("R9 index unmoved");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule